// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is a word-addressed control register file for a processor core module. Software reaches it through a plain register bus made of an access strobe, a write enable, a byte address and 32-bit write data. Read data and an error flag come back one clock after the access. The bank holds the oscillator settings, which sit behind a 16-bit unlock key. It also holds two software flag words with separate set and clear addresses, a one-bit software interrupt with independent IRQ and FIQ enable masks, and a control word. The control word drives a boot-remap select, an LED and a board-reset request.

A 64-word window of the address space serves bytes of a memory-module identification table as read-only data. Registers for SDRAM timing, bus initialisation and voltage control are present only as fixed read values. The bank does not generate clocks, control memory or remap anything itself. It only drives the select lines that other logic uses. There is no back-pressure: every access is accepted in the cycle its strobe is high.

Top module: `cm_ctrl_bank`

## Requirements
- R1: After reset the bank reads as follows. Word 0 (oscillator) reads 0x01000048 and word 7 (auxiliary oscillator) reads 0x0007FEFF. Word 8 always reads 0x00011122 and word 9 always reads 0x00000112, and writes to words 8 and 9 are accepted but change nothing. The flags, enables, soft level and control word are zero. remap_flash_o is 1, and led_o, irq_o, fiq_o, board_rst_o, bus_err and bus_rdata are 0.
- R2: The word index is bus_addr shifted right by 2. An access is taken at the clock edge where bus_en is high. bus_rdata and bus_err are registered from that edge. bus_rdata is the read value for a legal read and 0 otherwise.
- R3: A write to word 5 stores bits 15:0 of the data as the lock value. A read of word 5 returns the lock value in bits 15:0, plus bit 16 set when the lock value differs from 0xA05F.
- R4: Writes to word 0 and word 7 replace the register only while the lock value equals 0xA05F. Otherwise the register keeps its value.
- R5: Word 12 ORs the data into the flags and word 13 clears the flag bits that are 1 in the data. Words 14 and 15 do the same for the second (non-volatile) flag word. Both words read back at 12 and 14.
- R6: Word 18 ORs the data into the IRQ enable and word 19 clears bits of it. Words 26 and 27 do the same for the FIQ enable. Each enable reads back at its set word.
- R7: A write to word 20 with data bit 0 set raises the soft level. A write to word 21 with data bit 0 set lowers it. Other data bits have no effect. Word 20 reads the level in bit 0.
- R8: Words 17 and 25 read the raw level. Word 16 reads the level ANDed with the IRQ enable and word 24 reads the level ANDed with the FIQ enable. irq_o (respectively fiq_o) is 1 one clock after the state in which the level AND enable bit 0 of the matching mask is 1.
- R9: A write to word 3 stores data bits 0 and 2, and word 3 reads them back with all other bits 0. remap_flash_o is the inverse of stored bit 2 and led_o is stored bit 0. A write to word 3 with bit 3 set makes board_rst_o high for exactly the next cycle.
- R10: Words 64 to 127 (byte offsets 0x100 to 0x1FF) are read-only. Each reads table entry n (n = word index) zero-extended. Entry 64 holds a size code derived from MEM_MB: 64 if MEM_MB is at least 256, 32 if at least 128, 16 if at least 64, 4 if at least 32, else 2. Entries 73 to 83 hold the ASCII text "CTLBANK-MEM" in order, and all other entries are 0.
- R11: Words 32 to 35 read as 0 and accept writes without error and without effect.
- R12: Certain accesses return rdata 0 and set bus_err for one cycle. These are a read of word 13, 15, 19, 21 or 27, a write to word 16, 17, 24, 25 or 64 to 127, and any access to any other word not named above. Such an access changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered undefined-access flag |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |
| remap_flash_o | output | 1 | 1 = flash alias at address zero |
| led_o | output | 1 | LED drive |
| board_rst_o | output | 1 | One-cycle board-reset request |

## Verification
The embedded properties check several rules on every cycle. The oscillator words never change without a keyed write. The reset request only follows a control write with bit 3. The error flag only follows an access. The voltage words always read zero. The remap select holds between control writes. The interrupt outputs track the masked level one cycle later. Set/clear arithmetic, the lock status bit, the bit-0-only soft interrupt, the exact legal/illegal split between reads and writes, and the identification table contents can only be shown by the bench. It does this through full sweeps of all 256 word indices against a reference model, before and after a write sweep.

// File: rtl/cm_ctrl_pkg.sv
package cm_ctrl_pkg;

  localparam int unsigned IDX_OSC     = 0;
  localparam int unsigned IDX_CTRL    = 3;
  localparam int unsigned IDX_LOCK    = 5;
  localparam int unsigned IDX_AUX     = 7;
  localparam int unsigned IDX_SDRAM   = 8;
  localparam int unsigned IDX_INIT    = 9;
  localparam int unsigned IDX_FLG_S   = 12;
  localparam int unsigned IDX_FLG_C   = 13;
  localparam int unsigned IDX_NVF_S   = 14;
  localparam int unsigned IDX_NVF_C   = 15;
  localparam int unsigned IDX_ISTAT   = 16;
  localparam int unsigned IDX_IRAW    = 17;
  localparam int unsigned IDX_IEN_S   = 18;
  localparam int unsigned IDX_IEN_C   = 19;
  localparam int unsigned IDX_SW_S    = 20;
  localparam int unsigned IDX_SW_C    = 21;
  localparam int unsigned IDX_FSTAT   = 24;
  localparam int unsigned IDX_FRAW    = 25;
  localparam int unsigned IDX_FEN_S   = 26;
  localparam int unsigned IDX_FEN_C   = 27;
  localparam int unsigned IDX_VOLT_LO = 32;
  localparam int unsigned IDX_VOLT_HI = 35;
  localparam int unsigned IDX_TBL_LO  = 64;
  localparam int unsigned IDX_TBL_HI  = 127;

  // number of set/clear register cells (flags, nv flags, irq en, fiq en)
  localparam int unsigned SC_CELLS = 4;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_OSC, SEL_CTRL, SEL_LOCK, SEL_AUX, SEL_SDRAM, SEL_INIT,
    SEL_FLG_S, SEL_FLG_C, SEL_NVF_S, SEL_NVF_C,
    SEL_ISTAT, SEL_IRAW, SEL_IEN_S, SEL_IEN_C, SEL_SW_S, SEL_SW_C,
    SEL_FSTAT, SEL_FRAW, SEL_FEN_S, SEL_FEN_C, SEL_VOLT, SEL_TABLE
  } reg_sel_e;

  localparam int unsigned ID_TEXT_LO  = 73;
  localparam int unsigned ID_TEXT_LEN = 11;
  localparam logic [8*ID_TEXT_LEN-1:0] ID_TEXT = "CTLBANK-MEM";

  function automatic logic [7:0] size_code(input int unsigned mb);
    if (mb >= 256) return 8'd64;
    if (mb >= 128) return 8'd32;
    if (mb >= 64)  return 8'd16;
    if (mb >= 32)  return 8'd4;
    return 8'd2;
  endfunction

  function automatic logic [7:0] id_byte(input logic [6:0] ent, input int unsigned mb);
    int unsigned e;
    e = int'(ent);
    if (e == IDX_TBL_LO) return size_code(mb);
    if (e >= ID_TEXT_LO && e < ID_TEXT_LO + ID_TEXT_LEN)
      return ID_TEXT[8*(ID_TEXT_LO + ID_TEXT_LEN - 1 - e) +: 8];
    return 8'd0;
  endfunction

endpackage

// File: rtl/cm_decode.sv
module cm_decode
  import cm_ctrl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  output reg_sel_e         sel,
  output logic             legal
);

  always_comb begin
    case (int'(idx)) inside
      IDX_OSC:                   sel = SEL_OSC;
      IDX_CTRL:                  sel = SEL_CTRL;
      IDX_LOCK:                  sel = SEL_LOCK;
      IDX_AUX:                   sel = SEL_AUX;
      IDX_SDRAM:                 sel = SEL_SDRAM;
      IDX_INIT:                  sel = SEL_INIT;
      IDX_FLG_S:                 sel = SEL_FLG_S;
      IDX_FLG_C:                 sel = SEL_FLG_C;
      IDX_NVF_S:                 sel = SEL_NVF_S;
      IDX_NVF_C:                 sel = SEL_NVF_C;
      IDX_ISTAT:                 sel = SEL_ISTAT;
      IDX_IRAW:                  sel = SEL_IRAW;
      IDX_IEN_S:                 sel = SEL_IEN_S;
      IDX_IEN_C:                 sel = SEL_IEN_C;
      IDX_SW_S:                  sel = SEL_SW_S;
      IDX_SW_C:                  sel = SEL_SW_C;
      IDX_FSTAT:                 sel = SEL_FSTAT;
      IDX_FRAW:                  sel = SEL_FRAW;
      IDX_FEN_S:                 sel = SEL_FEN_S;
      IDX_FEN_C:                 sel = SEL_FEN_C;
      [IDX_VOLT_LO:IDX_VOLT_HI]: sel = SEL_VOLT;
      [IDX_TBL_LO:IDX_TBL_HI]:   sel = SEL_TABLE;
      default:                   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_NONE:                                          legal = 1'b0;
      SEL_FLG_C, SEL_NVF_C, SEL_IEN_C, SEL_SW_C, SEL_FEN_C: legal = we;
      SEL_ISTAT, SEL_IRAW, SEL_FSTAT, SEL_FRAW, SEL_TABLE:  legal = ~we;
      default:                                           legal = 1'b1;
    endcase
  end

endmodule

// File: rtl/cm_key_regs.sv
module cm_key_regs #(
  parameter int          DATA_W  = 32,
  parameter int          KEY_W   = 16,
  parameter logic [15:0] KEY     = 16'hA05F,
  parameter logic [31:0] OSC_RST = 32'h0100_0048,
  parameter logic [31:0] AUX_RST = 32'h0007_FEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              wr_osc,
  input  logic              wr_aux,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  lock_q,
  output logic              unlocked,
  output logic [DATA_W-1:0] osc_q,
  output logic [DATA_W-1:0] aux_q
);

  assign unlocked = (lock_q == KEY[KEY_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      osc_q  <= OSC_RST[DATA_W-1:0];
      aux_q  <= AUX_RST[DATA_W-1:0];
    end else begin
      if (wr_lock)             lock_q <= wdata[KEY_W-1:0];
      if (wr_osc && unlocked)  osc_q  <= wdata;
      if (wr_aux && unlocked)  aux_q  <= wdata;
    end
  end

  // R4
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_osc && unlocked) |=> $stable(osc_q));

  // R4
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_aux && unlocked) |=> $stable(aux_q));

endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int          W   = 32,
  parameter logic [31:0] RST = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST[W-1:0];
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

endmodule

// File: rtl/cm_int_out.sv
module cm_int_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_set,
  input  logic              sw_clr,
  input  logic              wbit0,
  input  logic [DATA_W-1:0] irq_en,
  input  logic [DATA_W-1:0] fiq_en,
  output logic              level_q,
  output logic              irq_o,
  output logic              fiq_o
);

  logic [DATA_W-1:0] lvl_vec;
  assign lvl_vec = {{(DATA_W-1){1'b0}}, level_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      if (sw_set && wbit0)      level_q <= 1'b1;
      else if (sw_clr && wbit0) level_q <= 1'b0;
      irq_o <= |(lvl_vec & irq_en);
      fiq_o <= |(lvl_vec & fiq_en);
    end
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q && irq_en[0]) |=> irq_o);

  // R8
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(level_q && fiq_en[0]) |=> !fiq_o);

endmodule

// File: rtl/cm_ctrl_bank.sv
module cm_ctrl_bank
  import cm_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 32,
  parameter int unsigned MEM_MB    = 128,
  parameter logic [15:0] LOCK_KEY  = 16'hA05F,
  parameter logic [31:0] OSC_RST   = 32'h0100_0048,
  parameter logic [31:0] AUX_RST   = 32'h0007_FEFF,
  parameter logic [31:0] SDRAM_VAL = 32'h0001_1122,
  parameter logic [31:0] INIT_VAL  = 32'h0000_0112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              remap_flash_o,
  output logic              led_o,
  output logic              board_rst_o
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int KEY_W  = 16;
  localparam int CTRL_LED   = 0;
  localparam int CTRL_REMAP = 2;
  localparam int CTRL_RST   = 3;

  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;
  logic             legal;
  logic             wr;

  assign idx = bus_addr[ADDR_W-1:2];

  cm_decode #(.IDX_W(IDX_W)) u_dec (
    .idx   (idx),
    .we    (bus_we),
    .sel   (sel),
    .legal (legal)
  );

  assign wr = bus_en && bus_we && legal;

  // keyed oscillator registers
  logic [KEY_W-1:0]  lock_q;
  logic              unlocked;
  logic [DATA_W-1:0] osc_q, aux_q;

  cm_key_regs #(
    .DATA_W (DATA_W), .KEY_W(KEY_W), .KEY(LOCK_KEY),
    .OSC_RST(OSC_RST), .AUX_RST(AUX_RST)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lock  (wr && sel == SEL_LOCK),
    .wr_osc   (wr && sel == SEL_OSC),
    .wr_aux   (wr && sel == SEL_AUX),
    .wdata    (bus_wdata),
    .lock_q   (lock_q),
    .unlocked (unlocked),
    .osc_q    (osc_q),
    .aux_q    (aux_q)
  );

  // set/clear cells: 0 flags, 1 nv flags, 2 irq enable, 3 fiq enable
  logic [SC_CELLS-1:0] sc_set, sc_clr;
  logic [DATA_W-1:0]   sc_q [SC_CELLS];

  assign sc_set = {wr && sel == SEL_FEN_S, wr && sel == SEL_IEN_S,
                   wr && sel == SEL_NVF_S, wr && sel == SEL_FLG_S};
  assign sc_clr = {wr && sel == SEL_FEN_C, wr && sel == SEL_IEN_C,
                   wr && sel == SEL_NVF_C, wr && sel == SEL_FLG_C};

  for (genvar g = 0; g < SC_CELLS; g++) begin : g_sc
    cm_setclr_reg #(.W(DATA_W), .RST(32'h0)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (sc_set[g]),
      .clr_en (sc_clr[g]),
      .wdata  (bus_wdata),
      .q      (sc_q[g])
    );
  end

  // soft interrupt and registered request outputs
  logic level_q;

  cm_int_out #(.DATA_W(DATA_W)) u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_set  (wr && sel == SEL_SW_S),
    .sw_clr  (wr && sel == SEL_SW_C),
    .wbit0   (bus_wdata[0]),
    .irq_en  (sc_q[2]),
    .fiq_en  (sc_q[3]),
    .level_q (level_q),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  // control word
  logic ctrl_led_q, ctrl_remap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_led_q   <= 1'b0;
      ctrl_remap_q <= 1'b0;
      board_rst_o  <= 1'b0;
    end else begin
      board_rst_o <= wr && sel == SEL_CTRL && bus_wdata[CTRL_RST];
      if (wr && sel == SEL_CTRL) begin
        ctrl_led_q   <= bus_wdata[CTRL_LED];
        ctrl_remap_q <= bus_wdata[CTRL_REMAP];
      end
    end
  end

  assign led_o         = ctrl_led_q;
  assign remap_flash_o = ~ctrl_remap_q;

  // read mux
  logic [DATA_W-1:0] lvl_vec, rd_val;
  assign lvl_vec = {{(DATA_W-1){1'b0}}, level_q};

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_OSC:   rd_val = osc_q;
      SEL_CTRL:  begin
        rd_val[CTRL_LED]   = ctrl_led_q;
        rd_val[CTRL_REMAP] = ctrl_remap_q;
      end
      SEL_LOCK:  rd_val = {{(DATA_W-KEY_W-1){1'b0}}, ~unlocked, lock_q};
      SEL_AUX:   rd_val = aux_q;
      SEL_SDRAM: rd_val = SDRAM_VAL[DATA_W-1:0];
      SEL_INIT:  rd_val = INIT_VAL[DATA_W-1:0];
      SEL_FLG_S: rd_val = sc_q[0];
      SEL_NVF_S: rd_val = sc_q[1];
      SEL_ISTAT: rd_val = lvl_vec & sc_q[2];
      SEL_IRAW:  rd_val = lvl_vec;
      SEL_IEN_S: rd_val = sc_q[2];
      SEL_SW_S:  rd_val = lvl_vec;
      SEL_FSTAT: rd_val = lvl_vec & sc_q[3];
      SEL_FRAW:  rd_val = lvl_vec;
      SEL_FEN_S: rd_val = sc_q[3];
      SEL_TABLE: rd_val = {{(DATA_W-8){1'b0}}, id_byte(idx[6:0], MEM_MB)};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_en && !bus_we && legal) ? rd_val : '0;
      bus_err   <= bus_en && !legal;
    end
  end

  // R9
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |-> $past(bus_en && bus_we && int'(idx) == IDX_CTRL && bus_wdata[CTRL_RST]));

  // R9
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && int'(idx) == IDX_CTRL) |=> $stable(remap_flash_o));

  // R12
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_en));

  // R11
  volt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && int'(idx) >= IDX_VOLT_LO && int'(idx) <= IDX_VOLT_HI)
      |=> (bus_rdata == '0 && !bus_err));

endmodule

// File: tb/cm_ctrl_bank_test.sv
module cm_ctrl_bank_test;

  localparam int          ADDR_W = 10;
  localparam int unsigned MEM_MB = 128;
  localparam logic [15:0] KEY    = 16'hA05F;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_err, irq_o, fiq_o, remap_flash_o, led_o, board_rst_o;

  always #4 clk = ~clk;

  cm_ctrl_bank #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_o(irq_o), .fiq_o(fiq_o),
    .remap_flash_o(remap_flash_o), .led_o(led_o), .board_rst_o(board_rst_o)
  );

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [31:0] m_osc = 32'h0100_0048, m_aux = 32'h0007_FEFF;
  logic [31:0] m_flg = 0, m_nvf = 0, m_ien = 0, m_fen = 0;
  logic [15:0] m_lock = 0;
  logic        m_lvl = 0, m_led = 0, m_rmp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    if (i == 0 || i == 7) return "R4";
    if (i == 5) return "R3";
    if (i == 3) return "R9";
    if (i == 8 || i == 9) return "R1";
    if (i >= 12 && i <= 15) return "R5";
    if (i == 16 || i == 17 || i == 24 || i == 25) return "R8";
    if (i == 18 || i == 19 || i == 26 || i == 27) return "R6";
    if (i == 20 || i == 21) return "R7";
    if (i >= 32 && i <= 35) return "R11";
    if (i >= 64 && i <= 127) return "R10";
    return "R12";
  endfunction

  function automatic bit exp_legal(input int i, input bit we);
    if (i inside {0, 3, 5, 7, 8, 9, 12, 14, 18, 20, 26} || (i >= 32 && i <= 35)) return 1'b1;
    if (i inside {13, 15, 19, 21, 27}) return we;
    if (i inside {16, 17, 24, 25} || (i >= 64 && i <= 127)) return !we;
    return 1'b0;
  endfunction

  function automatic logic [7:0] tbl(input int i);
    string txt = "CTLBANK-MEM";
    if (i == 64) return (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
                        (MEM_MB >= 64) ? 8'd16 : (MEM_MB >= 32) ? 8'd4 : 8'd2;
    if (i >= 73 && i <= 83) return txt[i-73];
    return 8'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input int i);
    case (i)
      0:  return m_osc;
      3:  return {29'b0, m_rmp, 1'b0, m_led};
      5:  return {15'b0, m_lock != KEY, m_lock};
      7:  return m_aux;
      8:  return 32'h0001_1122;
      9:  return 32'h0000_0112;
      12: return m_flg;
      14: return m_nvf;
      16: return {31'b0, m_lvl & m_ien[0]};
      17, 20, 25: return {31'b0, m_lvl};
      18: return m_ien;
      24: return {31'b0, m_lvl & m_fen[0]};
      26: return m_fen;
      default: return (i >= 64 && i <= 127) ? {24'b0, tbl(i)} : 32'h0;
    endcase
  endfunction

  task automatic access(input int i, input bit we, input logic [31:0] d);
    bit lg, pi, pf, er;
    logic [31:0] erd;
    string rq;
    rq  = req_of(i);
    lg  = exp_legal(i, we);
    erd = (!we && lg) ? exp_rd(i) : 32'h0;
    pi  = m_lvl & m_ien[0];
    pf  = m_lvl & m_fen[0];
    er  = we && lg && i == 3 && d[3];
    if (we && lg) begin
      case (i)
        0:  if (m_lock == KEY) m_osc = d;
        3:  begin m_led = d[0]; m_rmp = d[2]; end
        5:  m_lock = d[15:0];
        7:  if (m_lock == KEY) m_aux = d;
        12: m_flg |= d;
        13: m_flg &= ~d;
        14: m_nvf |= d;
        15: m_nvf &= ~d;
        18: m_ien |= d;
        19: m_ien &= ~d;
        20: if (d[0]) m_lvl = 1'b1;
        21: if (d[0]) m_lvl = 1'b0;
        26: m_fen |= d;
        27: m_fen &= ~d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = ADDR_W'(i * 4); bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0;
    chk(bus_rdata == erd, rq, $sformatf("rdata word %0d", i), bus_rdata, erd);
    chk(bus_err == !lg, "R12", $sformatf("err word %0d we %0d", i, we), 32'(bus_err), 32'(!lg));
    chk(irq_o == pi, "R8", "irq_o", 32'(irq_o), 32'(pi));
    chk(fiq_o == pf, "R8", "fiq_o", 32'(fiq_o), 32'(pf));
    chk(board_rst_o == er, "R9", "board_rst_o", 32'(board_rst_o), 32'(er));
    chk(remap_flash_o == !m_rmp, "R9", "remap_flash_o", 32'(remap_flash_o), 32'(!m_rmp));
    chk(led_o == m_led, "R9", "led_o", 32'(led_o), 32'(m_led));
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    chk(remap_flash_o == 1'b1, "R1", "reset remap", 32'(remap_flash_o), 32'd1);
    chk({led_o, irq_o, fiq_o, board_rst_o, bus_err} == 5'b0, "R1", "reset outputs",
        32'({led_o, irq_o, fiq_o, board_rst_o, bus_err}), 32'd0);
    chk(bus_rdata == 0, "R2", "reset rdata", bus_rdata, 32'd0);
    // R1 R10 R12 full read sweep of reset contents
    for (int i = 0; i < 256; i++) access(i, 1'b0, 32'h0);
    // R4 locked writes ignored, unlocked accepted
    access(0, 1'b1, 32'hDEAD_BEEF); access(7, 1'b1, 32'h1234_5678);
    access(0, 1'b0, 0); access(7, 1'b0, 0);
    access(5, 1'b1, 32'hFFFF_A05F); access(5, 1'b0, 0);           // R3
    access(0, 1'b1, 32'h1111_1111); access(7, 1'b1, 32'h2222_2222);
    access(0, 1'b0, 0); access(7, 1'b0, 0);
    access(5, 1'b1, 32'h0000_A05E); access(5, 1'b0, 0);           // R3
    access(0, 1'b1, 32'h3333_3333); access(0, 1'b0, 0);
    // R5 set/clear patterns on both flag words
    for (int p = 0; p < 6; p++) begin
      logic [31:0] s = 32'h1 << (p * 5) | 32'hF0 >> p;
      for (int w = 12; w <= 14; w += 2) begin
        access(w, 1'b1, s);         access(w, 1'b0, 0);
        access(w + 1, 1'b1, s >> 2); access(w, 1'b0, 0);
      end
    end
    // R6 R7 R8 all enable/level combinations
    for (int c = 0; c < 8; c++) begin
      access(19, 1'b1, 32'hFFFF_FFFF); access(27, 1'b1, 32'hFFFF_FFFF);
      access(21, 1'b1, 32'hFFFF_FFFF);
      access(18, 1'b1, 32'hFFFF_0000 | 32'(c & 1));
      access(26, 1'b1, 32'h00F0_0000 | 32'((c >> 1) & 1));
      access(20, 1'b1, 32'hFFFF_FFFE | 32'((c >> 2) & 1));   // R7 only bit 0 counts
      access(21, 1'b1, 32'hFFFF_FFFE);
      foreach (c_rd[k]) access(c_rd[k], 1'b0, 0);
    end
    // R9 every low control nibble
    for (int v = 0; v < 16; v++) begin
      access(3, 1'b1, 32'hFFFF_FFF0 | 32'(v)); access(3, 1'b0, 0);
    end
    // write sweep then read sweep (R11 R12 on writes)
    for (int i = 0; i < 256; i++) access(i, 1'b1, 32'h5A5A_0000 | 32'(i * 257));
    for (int i = 0; i < 256; i++) access(i, 1'b0, 0);
  endtask

  int c_rd [6] = '{16, 17, 18, 24, 25, 26};

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule